// File: doc/BRIEF.md
# Text Mode Fetch Address Generator

This block drives the VRAM reads that a video processor needs to draw one scan line of a character-based text screen. When the scan timing asks for a line, the block captures the layout settings: the wide-mode flag, the name table base field, the pattern table base field, the character row and the pixel line inside the glyph. It then walks the character cells from left to right. For each cell it first reads the character code from the name table. It then reads the glyph byte for that code from the pattern table. Last, it writes the glyph's pixels into a line buffer that is 512 pixels wide.

Two layouts are supported. The narrow layout has 40 cells per row. The wide layout has 80 cells per row and 24 visible rows. In the wide layout the two low bits of the name base field are treated as zero, so the name table can only sit on a 4 KB boundary. Each cell is 6 pixels wide, which gives 240 or 480 pixels per line. The VRAM returns read data in the cycle after the address is presented, and the pattern address is formed straight from that returned code.

Top module: `text_fetch_gen`

## Requirements
- R1: After reset, `vram_rd`, `pix_we`, `busy` and `line_done` are all low.
- R2: With `mode_wide` = 0, the name address for cell c of row r is (`name_base` << 10) + r*40 + c, taken modulo 16384 (14 bits).
- R3: With `mode_wide` = 1, bits 1:0 of `name_base` have no effect. The base is `name_base[3:2]` << 12.
- R4: With `mode_wide` = 1, the name address is base + r*80 + c, and a line holds 80 cells.
- R5: The pattern address is {`pat_base[2:0]`, code[7:0], `glyph_line[2:0]`}. Here code is the byte returned for that cell's name read.
- R6: For each cell there are exactly two reads, on consecutive cycles: the name read first, then the pattern read. Read data is expected on `vram_data` one cycle after each address.
- R7: Each cell writes 6 pixels at x = 6*c + k, for k = 0..5. Pixel k is bit 7-k of the glyph byte, so bits 1:0 of the byte are not drawn. `pix_x` rises by one on consecutive writes within a cell, and no pixel is written during a read.
- R8: A line makes exactly 2*W reads and 6*W pixel writes (W = 40 or 80). `pix_x` stays below 480. After the line, `line_done` pulses for one cycle while `busy` is already low.
- R9: The settings are captured when `line_go` is accepted. Changes to them during a line do not affect that line.
- R10: A `line_go` pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_go | input | 1 | Request to fetch and draw one line |
| mode_wide | input | 1 | 1 selects the 80-cell layout, 0 selects the 40-cell layout |
| name_base | input | 4 | Name table base field |
| pat_base | input | 3 | Pattern table base field |
| char_row | input | 5 | Character row index |
| glyph_line | input | 3 | Pixel line inside the glyph |
| vram_data | input | 8 | Read data, valid one cycle after the address |
| vram_rd | output | 1 | Read strobe |
| vram_addr | output | 14 | Read address |
| pix_we | output | 1 | Line buffer write strobe |
| pix_x | output | 9 | Line buffer pixel position |
| pix_on | output | 1 | Pixel value (foreground when 1) |
| busy | output | 1 | A line is in progress |
| line_done | output | 1 | One-cycle pulse at the end of a line |

## Verification
The bench builds the block with its default parameters: 14-bit addresses, 6-pixel cells, 40 and 80 cell layouts, 5-bit row and 3-bit glyph line inputs, and a 512-pixel buffer. Because the row input is 5 bits wide, rows past the visible 24 can be driven. In the narrow layout with the highest base value, this pushes the name address past the top of the 16 KB space and makes the wrap observable. Setting the low name-base bits in wide mode exposes whether they are forced to zero.

// File: rtl/text_fetch_pkg.sv
package text_fetch_pkg;

    localparam int VA_W        = 14;
    localparam int NREG_W      = 4;
    localparam int PREG_W      = 3;
    localparam int ROW_W       = 5;
    localparam int GLY_W       = 3;
    localparam int CODE_W      = 8;
    localparam int CELL_PX     = 6;
    localparam int COLS_NARROW = 40;
    localparam int COLS_WIDE   = 80;
    localparam int LBUF_PX     = 512;

    localparam int NBASE_SH = VA_W - NREG_W;
    localparam int COL_W    = $clog2(COLS_WIDE);
    localparam int SUB_W    = $clog2(CELL_PX);
    localparam int X_W      = $clog2(LBUF_PX);
    localparam int WIDE_KEEP = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NAME,
        ST_PAT,
        ST_LOAD,
        ST_EMIT
    } fetch_state_t;

    typedef struct packed {
        logic              wide;
        logic [NREG_W-1:0] nreg;
        logic [PREG_W-1:0] preg;
        logic [ROW_W-1:0]  row;
        logic [GLY_W-1:0]  gline;
    } line_cfg_t;

    function automatic logic [VA_W-1:0] name_addr_f(
        input logic              wide,
        input logic [NREG_W-1:0] nreg,
        input logic [ROW_W-1:0]  row,
        input logic [COL_W-1:0]  col
    );
        logic [NREG_W-1:0] eff;
        logic [VA_W-1:0]   base;
        logic [VA_W-1:0]   span;
        eff  = wide ? {nreg[NREG_W-1 -: WIDE_KEEP], {(NREG_W-WIDE_KEEP){1'b0}}} : nreg;
        base = {eff, {NBASE_SH{1'b0}}};
        span = wide ? VA_W'(COLS_WIDE) : VA_W'(COLS_NARROW);
        return base + VA_W'(row) * span + VA_W'(col);
    endfunction

    function automatic logic [VA_W-1:0] pat_addr_f(
        input logic [PREG_W-1:0] preg,
        input logic [CODE_W-1:0] code,
        input logic [GLY_W-1:0]  gline
    );
        return {preg, code, gline};
    endfunction

endpackage

// File: rtl/text_fetch_seq.sv
module text_fetch_seq
    import text_fetch_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             line_go,
    input  line_cfg_t        cfg_in,
    output line_cfg_t        cfg_q,
    output logic [COL_W-1:0] col,
    output logic             start,
    output logic             rd,
    output logic             pat_sel,
    output logic             load,
    output logic             emit,
    output logic             busy,
    output logic             done
);
    fetch_state_t     state;
    logic [SUB_W-1:0] sub;
    logic [COL_W-1:0] last_col;

    assign last_col = cfg_q.wide ? COL_W'(COLS_WIDE - 1) : COL_W'(COLS_NARROW - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cfg_q <= '0;
            col   <= '0;
            sub   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (line_go) begin
                        cfg_q <= cfg_in;
                        col   <= '0;
                        state <= ST_NAME;
                    end
                end
                ST_NAME: state <= ST_PAT;
                ST_PAT:  state <= ST_LOAD;
                ST_LOAD: begin
                    sub   <= '0;
                    state <= ST_EMIT;
                end
                ST_EMIT: begin
                    sub <= sub + 1'b1;
                    if (sub == SUB_W'(CELL_PX - 1)) begin
                        if (col == last_col) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            col   <= col + 1'b1;
                            state <= ST_NAME;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign start   = (state == ST_IDLE) && line_go;
    assign rd      = (state == ST_NAME) || (state == ST_PAT);
    assign pat_sel = (state == ST_PAT);
    assign load    = (state == ST_LOAD);
    assign emit    = (state == ST_EMIT);
    assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/text_fetch_addr.sv
module text_fetch_addr
    import text_fetch_pkg::*;
(
    input  line_cfg_t         cfg,
    input  logic [COL_W-1:0]  col,
    input  logic              pat_sel,
    input  logic [CODE_W-1:0] code,
    output logic [VA_W-1:0]   addr
);
    logic [VA_W-1:0] name_a;
    logic [VA_W-1:0] pat_a;

    always_comb begin
        name_a = name_addr_f(cfg.wide, cfg.nreg, cfg.row, col);
        pat_a  = pat_addr_f(cfg.preg, code, cfg.gline);
        addr   = pat_sel ? pat_a : name_a;
    end
endmodule

// File: rtl/text_fetch_shift.sv
module text_fetch_shift
    import text_fetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              load,
    input  logic              emit,
    input  logic [CODE_W-1:0] glyph,
    output logic [X_W-1:0]    x,
    output logic              pix
);
    logic [CODE_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
            x  <= '0;
        end else begin
            if (start) begin
                x <= '0;
            end else if (emit) begin
                x <= x + 1'b1;
            end
            if (load) begin
                sh <= glyph;
            end else if (emit) begin
                sh <= {sh[CODE_W-2:0], 1'b0};
            end
        end
    end

    assign pix = sh[CODE_W-1];
endmodule

// File: rtl/text_fetch_gen.sv
module text_fetch_gen
    import text_fetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              line_go,
    input  logic              mode_wide,
    input  logic [NREG_W-1:0] name_base,
    input  logic [PREG_W-1:0] pat_base,
    input  logic [ROW_W-1:0]  char_row,
    input  logic [GLY_W-1:0]  glyph_line,
    input  logic [CODE_W-1:0] vram_data,
    output logic              vram_rd,
    output logic [VA_W-1:0]   vram_addr,
    output logic              pix_we,
    output logic [X_W-1:0]    pix_x,
    output logic              pix_on,
    output logic              busy,
    output logic              line_done
);
    line_cfg_t        cfg_in;
    line_cfg_t        cfg_q;
    logic [COL_W-1:0] col;
    logic             start, pat_sel, load, emit;

    always_comb begin
        cfg_in.wide  = mode_wide;
        cfg_in.nreg  = name_base;
        cfg_in.preg  = pat_base;
        cfg_in.row   = char_row;
        cfg_in.gline = glyph_line;
    end

    text_fetch_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .line_go (line_go),
        .cfg_in  (cfg_in),
        .cfg_q   (cfg_q),
        .col     (col),
        .start   (start),
        .rd      (vram_rd),
        .pat_sel (pat_sel),
        .load    (load),
        .emit    (emit),
        .busy    (busy),
        .done    (line_done)
    );

    text_fetch_addr u_addr (
        .cfg     (cfg_q),
        .col     (col),
        .pat_sel (pat_sel),
        .code    (vram_data),
        .addr    (vram_addr)
    );

    text_fetch_shift u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .emit  (emit),
        .glyph (vram_data),
        .x     (pix_x),
        .pix   (pix_on)
    );

    assign pix_we = emit;
endmodule

// File: rtl/text_fetch_chk.sv
module text_fetch_chk
    import text_fetch_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            vram_rd,
    input logic            pix_we,
    input logic [X_W-1:0]  pix_x,
    input logic            busy,
    input logic            line_done
);
    a_r6_pat_follows_name: assert property (@(posedge clk) disable iff (rst)
        (vram_rd && !$past(vram_rd)) |=> vram_rd);

    a_r6_two_reads_per_cell: assert property (@(posedge clk) disable iff (rst)
        (vram_rd && $past(vram_rd)) |=> !vram_rd);

    a_r7_no_pixel_on_read: assert property (@(posedge clk) disable iff (rst)
        vram_rd |-> !pix_we);

    a_r7_x_steps_by_one: assert property (@(posedge clk) disable iff (rst)
        (pix_we && $past(pix_we)) |-> (pix_x == $past(pix_x) + 1'b1));

    a_r8_x_in_range: assert property (@(posedge clk) disable iff (rst)
        pix_we |-> (pix_x < X_W'(COLS_WIDE * CELL_PX)));

    a_r8_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        line_done |-> !busy);

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        line_done |=> !line_done);
endmodule

bind text_fetch_gen text_fetch_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .vram_rd   (vram_rd),
    .pix_we    (pix_we),
    .pix_x     (pix_x),
    .busy      (busy),
    .line_done (line_done)
);

// File: tb/text_fetch_gen_tb.sv
`timescale 1ns/1ps
module text_fetch_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_go = 1'b0;
    logic        mode_wide = 1'b0;
    logic [3:0]  name_base = '0;
    logic [2:0]  pat_base = '0;
    logic [4:0]  char_row = '0;
    logic [2:0]  glyph_line = '0;
    logic [7:0]  vram_data = '0;
    logic        vram_rd;
    logic [13:0] vram_addr;
    logic        pix_we;
    logic [8:0]  pix_x;
    logic        pix_on;
    logic        busy;
    logic        line_done;

    int checks = 0;
    int fails  = 0;
    logic [7:0] salt = 8'h00;

    always #2 clk = ~clk;

    text_fetch_gen u_dut (
        .clk(clk), .rst(rst), .line_go(line_go), .mode_wide(mode_wide),
        .name_base(name_base), .pat_base(pat_base), .char_row(char_row),
        .glyph_line(glyph_line), .vram_data(vram_data), .vram_rd(vram_rd),
        .vram_addr(vram_addr), .pix_we(pix_we), .pix_x(pix_x), .pix_on(pix_on),
        .busy(busy), .line_done(line_done)
    );

    function automatic logic [7:0] mem_f(input logic [13:0] a);
        logic [7:0] m;
        m = a[7:0] * 8'd29;
        return m ^ a[13:6] ^ salt;
    endfunction

    always @(posedge clk) begin
        if (vram_rd) vram_data <= mem_f(vram_addr);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(vram_rd == 0,   "R1", "vram_rd after reset", vram_rd, 0);
        chk(pix_we == 0,    "R1", "pix_we after reset", pix_we, 0);
        chk(busy == 0,      "R1", "busy after reset", busy, 0);
        chk(line_done == 0, "R1", "line_done after reset", line_done, 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_line(input bit m80, input logic [3:0] r2, input logic [2:0] r4,
                            input logic [4:0] row, input logic [2:0] gl,
                            input logic [7:0] s, input bit disturb, input string req);
        int w, nrd, npx, cyc, bad_name, bad_pat, bad_gap, bad_px, bad_ord, nx;
        int first_a, first_e;
        logic [13:0] rd_a [0:159];
        int          rd_c [0:159];
        logic [511:0] got;
        bit seen_done;
        w = m80 ? 80 : 40;
        nrd = 0; npx = 0; cyc = 0; seen_done = 0; nx = 0; bad_ord = 0;
        got = '0;
        salt = s;
        mode_wide = m80; name_base = r2; pat_base = r4;
        char_row = row; glyph_line = gl;
        line_go = 1'b1;
        @(negedge clk);
        line_go = 1'b0;
        while (!seen_done && cyc < 2000) begin
            if (vram_rd) begin
                if (nrd < 160) begin rd_a[nrd] = vram_addr; rd_c[nrd] = cyc; end
                nrd++;
            end
            if (pix_we) begin
                if (int'(pix_x) != nx) bad_ord++;
                got[pix_x] = pix_on;
                nx++;
                npx++;
            end
            if (line_done) begin
                seen_done = 1;
                chk(busy == 0, "R8", "busy during line_done", busy, 0);
            end
            if (disturb && cyc == 5) begin
                mode_wide = ~m80; name_base = ~r2; pat_base = ~r4;
                char_row = row + 5'd1; glyph_line = gl + 3'd1;
                line_go = 1'b1;
            end
            if (disturb && cyc == 6) line_go = 1'b0;
            @(negedge clk);
            cyc++;
        end
        chk(seen_done, "R8", "line_done seen", int'(seen_done), 1);
        chk(line_done == 0, "R8", "line_done width", line_done, 0);
        chk(nrd == 2 * w, {req, " R6"}, "read count", nrd, 2 * w);
        chk(npx == 6 * w, {req, " R7"}, "pixel count", npx, 6 * w);
        chk(bad_ord == 0, "R7", "pixel order errors", bad_ord, 0);
        bad_name = 0; bad_pat = 0; bad_gap = 0; bad_px = 0;
        first_a = 0; first_e = 0;
        if (nrd == 2 * w) begin
            for (int c = 0; c < w; c++) begin
                logic [13:0] base, na, pa;
                logic [7:0] code, gb;
                base = m80 ? {r2[3:2], 12'd0} : {r2, 10'd0};
                na = base + 14'(row) * 14'(w) + 14'(c);
                code = mem_f(na);
                pa = {r4, code, gl};
                gb = mem_f(pa);
                if (rd_a[2*c] != na) begin
                    if (bad_name == 0) begin first_a = rd_a[2*c]; first_e = na; end
                    bad_name++;
                end
                if (rd_a[2*c+1] != pa) bad_pat++;
                if (rd_c[2*c+1] != rd_c[2*c] + 1) bad_gap++;
                for (int k = 0; k < 6; k++)
                    if (got[c*6+k] != gb[7-k]) bad_px++;
            end
        end
        chk(bad_name == 0, req, "name address (first actual/expected)", first_a, first_e);
        chk(bad_pat == 0, {req, " R5"}, "pattern address errors", bad_pat, 0);
        chk(bad_gap == 0, "R6", "name/pattern read gap errors", bad_gap, 0);
        chk(bad_px == 0, {req, " R7"}, "pixel value errors", bad_px, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        run_line(1'b0, 4'hB, 3'h5, 5'd7,  3'd3, 8'h00, 1'b0, "R2");
        run_line(1'b0, 4'h2, 3'h1, 5'd0,  3'd0, 8'h5A, 1'b0, "R2");
        run_line(1'b0, 4'hF, 3'h7, 5'd31, 3'd7, 8'hC3, 1'b0, "R2");
        run_line(1'b1, 4'h3, 3'h2, 5'd23, 3'd5, 8'h11, 1'b0, "R3");
        run_line(1'b1, 4'hF, 3'h6, 5'd23, 3'd1, 8'h77, 1'b0, "R3");
        run_line(1'b1, 4'h4, 3'h0, 5'd12, 3'd6, 8'h9E, 1'b0, "R4");
        run_line(1'b0, 4'h6, 3'h3, 5'd9,  3'd2, 8'h21, 1'b1, "R9 R10");
        run_line(1'b1, 4'hA, 3'h4, 5'd17, 3'd4, 8'hE4, 1'b1, "R9 R10");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule